// File: doc/BRIEF.md
# MDIO Management Master

This block lets software read and write the 16-bit management registers of Ethernet PHYs over a two-wire serial management bus. Software reaches it through six 32-bit registers, selected by a 3-bit word index. It sets the target PHY and register, then does one of two things. Writing the data word starts a write frame. Toggling a read command bit from 0 to 1 starts a read frame. Software then polls an indicator register until the frame has finished.

The controller divides the system clock down to the management clock. It shifts out a 64-bit frame on the data pin and releases the pin while the PHY answers during a read. It gathers the sixteen returned bits into a status register. A soft reset bit in the configuration register aborts any frame in flight. A line that nobody drives is pulled high, so a read from an empty address returns all ones.

Top module: `mdio_master`

## Requirements
- R1: Register map, by word index: 0 configuration, 1 address, 2 write data, 3 command, 4 indicator, 5 read result. The address register holds the PHY address in bits 12:8 and the register number in bits 4:0, and reads back with all other bits zero.
- R2: Writing index 2 while idle starts a write frame, sent MSB first. Each bit is driven on one management clock period. The 64 bits are: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits.
- R3: A read frame starts only when bit 0 of the command register goes from 0 to 1. Its opcode is 10. Writing 1 again while the bit is already 1 starts nothing.
- R4: Indicator bit 0 (busy) is high from the cycle after the trigger until the frame has ended.
- R5: Indicator bit 1 (not-valid) is set when a read starts. It clears together with busy once all sixteen data bits have been sampled. The read result then sits in bits 15:0 of index 5.
- R6: The data output enable is high for all 64 bits of a write. For a read it is high for the first 46 bits and low from the turnaround to the end. It is low whenever the controller is idle.
- R7: The management clock period is 2×(N+1) system clocks, where N is configuration bits 2:0. The data output changes only at a falling management clock edge, and read data is sampled at the rising edge.
- R8: Writing configuration with bit 31 set aborts any frame. Busy, not-valid and the output enable are low in the next cycle, and the command bit is cleared. A configuration write with bit 31 clear loads N. N is 7 after reset.
- R9: A read from an address where no PHY answers returns 0xFFFF.
- R10: A write to index 2, or a command trigger, that arrives while busy is ignored. The write data register keeps its old value and no new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the index |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (resolved line) |

## Verification
Busy and not-valid rise in the cycle right after the register write, so the bench reads the indicator at the falling system-clock edge that follows. Frame bits appear only on management clock edges, so the bench watches the management clock at every falling system-clock edge. It records each bit at the rise that follows the fall which drove it, and drives its PHY model half a system cycle after that fall. Frame completion, the read result and the end of the output enable are checked only after the indicator reports both flags clear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W      = 32;
  localparam int PHY_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int DIV_W      = 3;
  localparam int PHY_LSB    = 8;
  localparam int RST_BIT    = 31;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * PHY_W + 2 + DATA_W;
  localparam int TA_POS     = PRE_BITS + 4 + 2 * PHY_W;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  typedef enum logic [2:0] {
    RI_CFG  = 3'd0,
    RI_ADDR = 3'd1,
    RI_CTRL = 3'd2,
    RI_CMD  = 3'd3,
    RI_IND  = 3'd4,
    RI_STAT = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick     = (cnt_q >= div);
  assign rise_stb = tick & ~mdc_q & ~clr;
  assign fall_stb = tick &  mdc_q & ~clr;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (clr) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [PHY_W-1:0]  phy,
  input  logic [PHY_W-1:0]  regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              nv,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_TA   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [DATA_W-1:0]     rx_q, rx_d, res_q, res_d;
  logic                  busy_q, busy_d, nv_q, nv_d, rd_q, rd_d, o_q, o_d, oe_q, oe_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    res_d  = res_q;
    busy_d = busy_q;
    nv_d   = nv_q;
    rd_d   = rd_q;
    o_d    = o_q;
    oe_d   = oe_q;
    if (clr) begin
      busy_d = 1'b0;
      nv_d   = 1'b0;
      oe_d   = 1'b0;
      cnt_d  = '0;
    end else if (!busy_q) begin
      if (start_wr || start_rd) begin
        busy_d = 1'b1;
        nv_d   = start_rd;
        rd_d   = start_rd;
        cnt_d  = '0;
        sh_d   = {{PRE_BITS{1'b1}}, 2'b01, (start_rd ? 2'b10 : 2'b01), phy, regn,
                  (start_rd ? 2'b11 : 2'b10), (start_rd ? {DATA_W{1'b1}} : wdata)};
      end
    end else if (fall_stb) begin
      if (cnt_q == CNT_END) begin
        busy_d = 1'b0;
        nv_d   = 1'b0;
        oe_d   = 1'b0;
        if (rd_q) res_d = rx_q;
      end else begin
        o_d   = sh_q[FRAME_BITS-1];
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        oe_d  = !(rd_q && (cnt_q >= CNT_TA));
        cnt_d = cnt_q + 1'b1;
      end
    end else if (rise_stb && rd_q && (cnt_q > CNT_DATA)) begin
      rx_d = {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      rx_q   <= '0;
      res_q  <= '0;
      busy_q <= 1'b0;
      nv_q   <= 1'b0;
      rd_q   <= 1'b0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      res_q  <= res_d;
      busy_q <= busy_d;
      nv_q   <= nv_d;
      rd_q   <= rd_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
    end
  end

  assign busy    = busy_q;
  assign nv      = nv_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign rd_data = res_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [PHY_W-1:0]  phy_q, phy_d, regn_q, regn_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d, rd_data;
  logic              cmd_q, cmd_d;
  logic              busy, nv, rise_stb, fall_stb;
  logic              soft_clr, start_wr, start_rd;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign soft_clr = reg_wr && (reg_idx == RI_CFG) && reg_wdata[RST_BIT];
  assign start_wr = reg_wr && (reg_idx == RI_CTRL) && !busy;
  assign start_rd = reg_wr && (reg_idx == RI_CMD) && reg_wdata[0] && !cmd_q && !busy;
  assign unused_wdata = ^{reg_wdata[RST_BIT-1:DATA_W]};

  always_comb begin
    div_d  = div_q;
    phy_d  = phy_q;
    regn_d = regn_q;
    ctrl_d = ctrl_q;
    cmd_d  = cmd_q;
    if (soft_clr) begin
      cmd_d = 1'b0;
    end else if (reg_wr) begin
      unique case (reg_idx)
        RI_CFG:  div_d = reg_wdata[DIV_W-1:0];
        RI_ADDR: begin
          phy_d  = reg_wdata[PHY_LSB +: PHY_W];
          regn_d = reg_wdata[0 +: PHY_W];
        end
        RI_CTRL: if (!busy) ctrl_d = reg_wdata[DATA_W-1:0];
        RI_CMD:  cmd_d = reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q  <= DIV_RST;
      phy_q  <= '0;
      regn_q <= '0;
      ctrl_q <= '0;
      cmd_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      phy_q  <= phy_d;
      regn_q <= regn_d;
      ctrl_q <= ctrl_d;
      cmd_q  <= cmd_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      RI_CFG:  reg_rdata[DIV_W-1:0] = div_q;
      RI_ADDR: begin
        reg_rdata[PHY_LSB +: PHY_W] = phy_q;
        reg_rdata[0 +: PHY_W]       = regn_q;
      end
      RI_CTRL: reg_rdata[DATA_W-1:0] = ctrl_q;
      RI_CMD:  reg_rdata[0] = cmd_q;
      RI_IND:  reg_rdata[1:0] = {nv, busy};
      RI_STAT: reg_rdata[DATA_W-1:0] = rd_data;
      default: reg_rdata = '0;
    endcase
  end

  mdio_clkgen u_clkgen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (soft_clr),
    .div      (div_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (soft_clr),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .phy      (phy_q),
    .regn     (regn_q),
    .wdata    (reg_wdata[DATA_W-1:0]),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .nv       (nv),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              nv,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              reg_wr,
  input logic [2:0]        reg_idx,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0] ctrl_q
);
  // R5: not-valid never outlives busy
  a_r5_nv_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv |-> busy);

  // R6: line released while idle
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R7: data output moves only with a falling management clock
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  // R6: output enable moves only with a falling management clock inside a frame
  a_r6_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_oe != $past(mdio_oe))) |-> $fell(mdc));

  // R8: soft reset idles the engine in the next cycle
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_idx == RI_CFG) && reg_wdata[RST_BIT]) |=> (!busy && !nv && !mdio_oe));

  // R10: data register untouched by writes during a frame
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_idx == RI_CTRL)) |=> $stable(ctrl_q));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .nv        (nv),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .reg_wr    (reg_wr),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .ctrl_q    (ctrl_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, reg_wr, mdc, mdio_o, mdio_oe, mdio_i;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam logic [4:0]  PHY_HERE = 5'd9;
  localparam logic [15:0] PHY_RESP = 16'hA5C3;

  // op(1) div(3) phy(5) reg(5) data(16)
  localparam logic [29:0] VEC [5] = '{
    {1'b0, 3'd1, 5'd3,  5'd17, 16'h1234},
    {1'b1, 3'd1, 5'd9,  5'd2,  16'h0000},
    {1'b1, 3'd0, 5'd4,  5'd5,  16'h0000},
    {1'b0, 3'd2, 5'd31, 5'd0,  16'h8001},
    {1'b1, 3'd3, 5'd9,  5'd31, 16'h0000}
  };

  int          fc, oe_cnt, rise_t, rise_prev;
  logic [63:0] cap;
  logic        phy_en, phy_bit, mdc_prev;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // bus monitor and PHY model, evaluated away from the active edge
  always @(negedge clk) begin
    if (mdc_prev && !mdc && (fc > 0 || mdio_oe)) begin
      fc = fc + 1;
      if (fc - 1 >= 48 && fc - 1 <= 63 && cap[29:28] == 2'b10 && cap[27:23] == PHY_HERE) begin
        phy_en  = 1'b1;
        phy_bit = PHY_RESP[63 - (fc - 1)];
      end else begin
        phy_en = 1'b0;
      end
    end
    if (!mdc_prev && mdc) begin
      rise_prev = rise_t;
      rise_t    = cyc;
      if (fc >= 1 && fc <= 64) begin
        cap[64 - fc] = mdio_i;
        if (mdio_oe) oe_cnt = oe_cnt + 1;
      end
    end
    mdc_prev = mdc;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual %0d expected <150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic mon_clear();
    fc = 0; oe_cnt = 0; cap = '0; phy_en = 1'b0; phy_bit = 1'b1;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit ok = 0;
    for (int i = 0; i < 6000; i++) begin
      rd(3'd4, v);
      if (v[1:0] == 2'b00) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(req, 64'(ok), 64'd1);
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] exp;
    mon_clear();
    mdc_prev = 1'b0; rise_t = 0; rise_prev = 0;
    reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(3'd4, v); chk("R4 reset indicator", 64'(v), 64'd0);
    rd(3'd0, v); chk("R8 reset divider", 64'(v), 64'd7);
    chk("R6 idle oe after reset", 64'(mdio_oe), 64'd0);

    // R1 field placement
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R1 address readback", 64'(v), 64'h1F1F);

    // vector table
    for (int k = 0; k < 5; k++) begin
      logic       is_rd;
      logic [2:0] dv;
      logic [4:0] ph, rg;
      logic [15:0] dt;
      {is_rd, dv, ph, rg, dt} = VEC[k];
      wr(3'd0, {29'd0, dv});
      wr(3'd1, {19'd0, ph, 3'd0, rg});
      mon_clear();
      if (is_rd) begin
        wr(3'd3, 32'd0);
        wr(3'd3, 32'd1);
      end else begin
        wr(3'd2, {16'd0, dt});
      end
      rd(3'd4, v);
      chk(is_rd ? "R5 not-valid and busy at read start" : "R4 busy at write start",
          64'(v[1:0]), is_rd ? 64'd3 : 64'd1);
      wait_done("R4 frame completes");
      exp = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), ph, rg, 2'b10, dt};
      if (is_rd) begin
        chk("R3 read frame header", 64'(cap[63:18]), 64'(exp[63:18]));
        chk("R6 read oe bits", 64'(oe_cnt), 64'd46);
        rd(3'd5, v);
        chk(ph == PHY_HERE ? "R5 read data" : "R9 empty address reads ones",
            64'(v), ph == PHY_HERE ? 64'(PHY_RESP) : 64'hFFFF);
      end else begin
        chk("R2 write frame bits", cap, exp);
        chk("R6 write oe bits", 64'(oe_cnt), 64'd64);
      end
      chk("R7 mdc period", 64'(rise_t - rise_prev), 64'(2 * (dv + 1)));
    end

    // R3: command bit still 1, writing 1 again starts nothing
    wr(3'd3, 32'd1);
    rd(3'd4, v); chk("R3 level does not retrigger", 64'(v), 64'd0);
    repeat (20) @(negedge clk);
    rd(3'd4, v); chk("R3 still idle", 64'(v), 64'd0);

    // R10: writes and triggers during a frame
    wr(3'd0, 32'd1);
    wr(3'd1, {19'd0, 5'd2, 3'd0, 5'd6});
    wr(3'd3, 32'd0);
    mon_clear();
    wr(3'd2, 32'h1111);
    wr(3'd2, 32'h2222);
    rd(3'd2, v); chk("R10 data ignored while busy", 64'(v), 64'h1111);
    wr(3'd3, 32'd1);
    wait_done("R10 frame completes");
    chk("R10 frame carries first data", 64'(cap[15:0]), 64'h1111);
    chk("R10 frame stayed a write", 64'(cap[29:28]), 64'h1);
    repeat (10) @(negedge clk);
    rd(3'd4, v); chk("R10 no read followed", 64'(v), 64'd0);

    // R8: soft reset mid-frame
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd2);
    mon_clear();
    wr(3'd2, 32'h00AA);
    repeat (60) @(negedge clk);
    rd(3'd4, v); chk("R4 busy mid frame", 64'(v), 64'd1);
    wr(3'd0, 32'h8000_0000);
    rd(3'd4, v); chk("R8 soft reset idles", 64'(v), 64'd0);
    chk("R8 soft reset releases line", 64'(mdio_oe), 64'd0);
    rd(3'd0, v); chk("R8 divider kept across soft reset", 64'(v), 64'd2);
    wr(3'd0, 32'd0);
    rd(3'd0, v); chk("R8 divider load", 64'(v), 64'd0);
    rd(3'd4, v); chk("R8 not busy after load", 64'(v), 64'd0);

    summary();
    $finish;
  end
endmodule